// File: doc/BRIEF.md
# Multi-Mode USART Bit-Clock Generator

This block derives the bit timing for a USART transmitter and receiver from the system clock. A 12-bit programmable down-counter divides the system clock. A mode-dependent post-divider then turns the counter's ticks into a transmit enable. The undivided tick serves as the receiver's base enable. Every output is a single-cycle enable pulse in the system clock domain; the block creates no derived clocks.

Three control inputs select one of four modes:
- `sync_sel` chooses asynchronous or synchronous operation.
- `dbl_speed` selects double-speed operation, and only in asynchronous mode.
- `xck_dir_out` is the pin-direction bit of the external clock pin. In synchronous mode it selects master or slave.

In master mode the block drives the external clock pin from its own divider. In slave mode it samples the pin through a synchronizer and an edge detector. The `clk_pol` input then chooses which edge times the transmitter and which times the receiver.

The divisor is written through two byte-wide strobes: one for the low eight bits and one for the upper four bits. Writing the low byte restarts the counter at once.

Top module: `usart_clkgen`

## Requirements
- R1: After reset the divisor is zero and the counters are cleared. In normal asynchronous mode, `rx_tick` is therefore high every cycle from the first cycle after reset release. `tx_tick` pulses on every 16th cycle, first in the 16th.
- R2: The prescaler counts down from the divisor D at the system clock rate and ticks when it reaches zero, which gives one tick every D+1 cycles. In asynchronous mode every prescaler tick appears on `rx_tick`.
- R3: A strobe on `div_wr_lo` loads the counter with {stored high nibble, `div_wdata`} at that clock edge. The first tick after the write therefore appears D cycles later, and the ticks then repeat every D+1 cycles.
- R4: A strobe on `div_wr_hi` stores `div_wdata[3:0]` as divisor bits 11:8 without restarting the counter. The new value takes effect at the next reload.
- R5: In normal asynchronous mode (`sync_sel`=0, `dbl_speed`=0), `tx_tick` pulses on every 16th prescaler tick.
- R6: In double-speed asynchronous mode (`sync_sel`=0, `dbl_speed`=1), `tx_tick` pulses on every 8th prescaler tick.
- R7: In master mode (`sync_sel`=1, `xck_dir_out`=1), the block behaves as follows:
  - `xck_oe` is 1.
  - `xck_out` toggles on each prescaler tick.
  - `rx_tick` equals the prescaler tick.
  - `tx_tick` pulses on the tick that makes `xck_out` rise (`clk_pol`=0) or fall (`clk_pol`=1), so it fires every second prescaler tick.
- R8: In asynchronous mode, `xck_oe` and `xck_out` are 0 and `xck_in` has no effect on any output.
- R9: In slave mode (`sync_sel`=1, `xck_dir_out`=0), `xck_in` passes through two synchronizer flops and an edge detector. A level change on `xck_in` captured at edge k yields a one-cycle pulse in the cycle after edge k+1. With `clk_pol`=0, a rising edge gives `tx_tick` and a falling edge gives `rx_tick`. With `clk_pol`=1, the two are swapped.
- R10: `rx_spb` gives the receiver's samples per bit as a binary value: 16 in normal asynchronous mode, 8 in double-speed asynchronous mode, and 2 in both synchronous modes.
- R11: In synchronous mode, `dbl_speed` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr_lo | input | 1 | Write strobe for divisor bits 7:0; restarts counter |
| div_wr_hi | input | 1 | Write strobe for divisor bits 11:8 |
| div_wdata | input | 8 | Write data for either divisor strobe |
| sync_sel | input | 1 | 0 asynchronous, 1 synchronous |
| dbl_speed | input | 1 | Double-speed select (asynchronous only) |
| xck_dir_out | input | 1 | External clock pin direction: 1 master, 0 slave |
| clk_pol | input | 1 | External clock edge polarity select |
| xck_in | input | 1 | External clock pin input |
| xck_out | output | 1 | External clock pin output value |
| xck_oe | output | 1 | External clock pin output enable |
| tx_tick | output | 1 | Transmitter bit enable pulse |
| rx_tick | output | 1 | Receiver base enable pulse |
| rx_spb | output | 5 | Receiver samples per bit |

## Verification
The checker assumes that the divisor is never written through both strobes in the same cycle. It also assumes that `xck_in` in slave mode holds each level for at least three system cycles, so that the synchronized edges do not merge. The random stimulus writes only one strobe per cycle and toggles `xck_in` at intervals of three to nine cycles. Mode bits change rarely and at random; after each change the reference model follows the same synchronizer clearing rules, with no special handling of the change.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

  typedef enum logic [1:0] {
    UCM_ASYNC_X16 = 2'd0,
    UCM_ASYNC_X8  = 2'd1,
    UCM_SYNC_MST  = 2'd2,
    UCM_SYNC_SLV  = 2'd3
  } ucm_mode_e;

  function automatic ucm_mode_e ucm_decode(input logic sync_sel,
                                           input logic dbl,
                                           input logic dir_out);
    ucm_mode_e m;
    if (!sync_sel) m = dbl ? UCM_ASYNC_X8 : UCM_ASYNC_X16;
    else           m = dir_out ? UCM_SYNC_MST : UCM_SYNC_SLV;
    return m;
  endfunction

endpackage

// File: rtl/usart_clkgen_divreg.sv
module usart_clkgen_divreg #(
  parameter int DIV_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [DIV_W-1:0] div_val,
  output logic             load,
  output logic [DIV_W-1:0] load_val
);
  localparam int HI_W = DIV_W - BUS_W;

  logic [HI_W-1:0]  hi_q, hi_d;
  logic [BUS_W-1:0] lo_q, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (wr_hi) hi_d = wdata[HI_W-1:0];
    if (wr_lo) lo_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= hi_d;
      if (wr_lo) lo_q <= lo_d;
    end
  end

  // Restart value combines the stored high part with the incoming low byte.
  assign div_val  = {hi_q, lo_q};
  assign load     = wr_lo;
  assign load_val = {hi_q, wdata};

endmodule

// File: rtl/usart_clkgen_presc.sv
module usart_clkgen_presc #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    if (load)         cnt_d = load_val;
    else if (at_zero) cnt_d = div_val;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_zero;

endmodule

// File: rtl/usart_clkgen_postdiv.sv
module usart_clkgen_postdiv #(
  parameter int PDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [PDIV_W-1:0] phase
);
  logic [PDIV_W-1:0] ph_q, ph_d;

  always_comb ph_d = ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= '0;
    else if (tick) ph_q <= ph_d;
  end

  assign phase = ph_q;

endmodule

// File: rtl/usart_clkgen_xsync.sv
module usart_clkgen_xsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] stg_q, stg_d;
  logic                   last_q, last_d;

  always_comb begin
    stg_d[0] = enable ? pin_in : 1'b0;
    last_d   = enable ? stg_q[SYNC_STAGES-1] : 1'b0;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
      assign stg_d[g] = enable ? stg_q[g-1] : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      last_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      last_q <= last_d;
    end
  end

  assign rise = stg_q[SYNC_STAGES-1] & ~last_q;
  assign fall = ~stg_q[SYNC_STAGES-1] & last_q;

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BUS_W       = 8,
  parameter int PDIV_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr_lo,
  input  logic              div_wr_hi,
  input  logic [BUS_W-1:0]  div_wdata,
  input  logic              sync_sel,
  input  logic              dbl_speed,
  input  logic              xck_dir_out,
  input  logic              clk_pol,
  input  logic              xck_in,
  output logic              xck_out,
  output logic              xck_oe,
  output logic              tx_tick,
  output logic              rx_tick,
  output logic [PDIV_W:0]   rx_spb
);
  localparam int          DBL_W    = PDIV_W - 1;
  localparam logic [PDIV_W:0] SPB_X16 = (PDIV_W+1)'(1) << PDIV_W;
  localparam logic [PDIV_W:0] SPB_X8  = (PDIV_W+1)'(1) << DBL_W;
  localparam logic [PDIV_W:0] SPB_SYN = (PDIV_W+1)'(2);

  ucm_mode_e          mode;
  logic [DIV_W-1:0]   div_val, load_val;
  logic               load, ptick, xrise, xfall, slave_en;
  logic [PDIV_W-1:0]  phase;

  assign mode     = ucm_decode(sync_sel, dbl_speed, xck_dir_out);
  assign slave_en = (mode == UCM_SYNC_SLV);

  usart_clkgen_divreg #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_divreg (
    .clk(clk), .rst_n(rst_n), .wr_lo(div_wr_lo), .wr_hi(div_wr_hi),
    .wdata(div_wdata), .div_val(div_val), .load(load), .load_val(load_val)
  );

  usart_clkgen_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .load(load),
    .load_val(load_val), .tick(ptick)
  );

  usart_clkgen_postdiv #(.PDIV_W(PDIV_W)) u_postdiv (
    .clk(clk), .rst_n(rst_n), .tick(ptick), .phase(phase)
  );

  usart_clkgen_xsync #(.SYNC_STAGES(SYNC_STAGES)) u_xsync (
    .clk(clk), .rst_n(rst_n), .enable(slave_en), .pin_in(xck_in),
    .rise(xrise), .fall(xfall)
  );

  always_comb begin
    tx_tick = 1'b0;
    rx_tick = 1'b0;
    xck_out = 1'b0;
    xck_oe  = 1'b0;
    rx_spb  = SPB_SYN;
    unique case (mode)
      UCM_ASYNC_X16: begin
        rx_tick = ptick;
        tx_tick = ptick & (&phase);
        rx_spb  = SPB_X16;
      end
      UCM_ASYNC_X8: begin
        rx_tick = ptick;
        tx_tick = ptick & (&phase[DBL_W-1:0]);
        rx_spb  = SPB_X8;
      end
      UCM_SYNC_MST: begin
        xck_oe  = 1'b1;
        xck_out = phase[0];
        rx_tick = ptick;
        tx_tick = ptick & (phase[0] == clk_pol);
      end
      default: begin
        tx_tick = clk_pol ? xfall : xrise;
        rx_tick = clk_pol ? xrise : xfall;
      end
    endcase
  end

endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk #(
  parameter int BUS_W  = 8,
  parameter int PDIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_wr_lo,
  input logic [BUS_W-1:0] div_wdata,
  input logic             sync_sel,
  input logic             xck_dir_out,
  input logic             xck_out,
  input logic             xck_oe,
  input logic             tx_tick,
  input logic             rx_tick,
  input logic [PDIV_W:0]  rx_spb
);
  logic mst, slv;
  assign mst = sync_sel & xck_dir_out;
  assign slv = sync_sel & ~xck_dir_out;

  // R8
  pin_idle_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_sel |-> (!xck_oe && !xck_out));

  // R7
  xck_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && !rx_tick) ##1 mst |-> $stable(xck_out));

  // R9
  slave_edges_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv |-> !(tx_tick && rx_tick));

  // R5
  tx_within_rx_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_sel && tx_tick) |-> rx_tick);

  // R3
  reload_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr_lo && div_wdata != '0) |=> (!rx_tick || slv));

  // R10
  spb_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_spb) == 1);

endmodule

bind usart_clkgen usart_clkgen_chk #(.BUS_W(BUS_W), .PDIV_W(PDIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_wr_lo(div_wr_lo), .div_wdata(div_wdata),
  .sync_sel(sync_sel), .xck_dir_out(xck_dir_out), .xck_out(xck_out),
  .xck_oe(xck_oe), .tx_tick(tx_tick), .rx_tick(rx_tick), .rx_spb(rx_spb)
);

// File: tb/test_usart_clkgen.sv
`timescale 1ns/1ps
module test_usart_clkgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_wr_lo, div_wr_hi;
  logic [7:0] div_wdata;
  logic       sync_sel, dbl_speed, xck_dir_out, clk_pol, xck_in;
  logic       xck_out, xck_oe, tx_tick, rx_tick;
  logic [4:0] rx_spb;

  int checks = 0;
  int fails  = 0;
  string phase_tag = "";

  always #2.5 clk = ~clk;

  usart_clkgen i_usart_clkgen (
    .clk(clk), .rst_n(rst_n), .div_wr_lo(div_wr_lo), .div_wr_hi(div_wr_hi),
    .div_wdata(div_wdata), .sync_sel(sync_sel), .dbl_speed(dbl_speed),
    .xck_dir_out(xck_dir_out), .clk_pol(clk_pol), .xck_in(xck_in),
    .xck_out(xck_out), .xck_oe(xck_oe), .tx_tick(tx_tick),
    .rx_tick(rx_tick), .rx_spb(rx_spb)
  );

  // Reference model built from the requirements
  logic [11:0] m_cnt;
  logic [3:0]  m_hi, m_ph;
  logic [7:0]  m_lo;
  logic        m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_hi = '0; m_lo = '0; m_ph = '0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic tk;
      tk = (m_cnt == 0);
      if (div_wr_lo)  m_cnt = {m_hi, div_wdata};
      else if (tk)    m_cnt = {m_hi, m_lo};
      else            m_cnt = m_cnt - 1;
      if (div_wr_hi) m_hi = div_wdata[3:0];
      if (div_wr_lo) m_lo = div_wdata;
      if (tk) m_ph = m_ph + 1;
      if (sync_sel && !xck_dir_out) begin
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = xck_in;
      end else begin
        m_s3 = 0; m_s2 = 0; m_s1 = 0;
      end
    end
  end

  function automatic string mode_tag(input bit is_tx);
    if (phase_tag != "") return phase_tag;
    if (!sync_sel) return is_tx ? (dbl_speed ? "R6" : "R5") : "R2";
    if (xck_dir_out) return "R7";
    return "R9";
  endfunction

  task automatic chk(input string tag, input string nm, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic pt, rise, fall;
    logic e_tx, e_rx, e_out, e_oe;
    int   e_spb;
    pt = (m_cnt == 0);
    rise = m_s2 & ~m_s3;
    fall = ~m_s2 & m_s3;
    e_tx = 0; e_rx = 0; e_out = 0; e_oe = 0; e_spb = 2;
    if (!sync_sel) begin
      e_rx = pt;
      e_tx = dbl_speed ? (pt && m_ph[2:0] == 3'd7) : (pt && m_ph == 4'd15);
      e_spb = dbl_speed ? 8 : 16;
    end else if (xck_dir_out) begin
      e_oe = 1; e_out = m_ph[0]; e_rx = pt;
      e_tx = pt && (m_ph[0] == clk_pol);
    end else begin
      e_tx = clk_pol ? fall : rise;
      e_rx = clk_pol ? rise : fall;
    end
    chk(mode_tag(1), "tx_tick", tx_tick, e_tx);
    chk(mode_tag(0), "rx_tick", rx_tick, e_rx);
    chk(sync_sel ? mode_tag(0) : "R8", "xck_out", xck_out, e_out);
    chk(sync_sel ? mode_tag(0) : "R8", "xck_oe", xck_oe, e_oe);
    chk(phase_tag != "" ? phase_tag : "R10", "rx_spb", rx_spb, e_spb);
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) check_all();
    div_wr_lo = 0;
    div_wr_hi = 0;
  endtask

  task automatic set_mode(input logic s, input logic d, input logic o, input logic p);
    sync_sel = s; dbl_speed = d; xck_dir_out = o; clk_pol = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hold;
    int first_gap;
    void'($urandom(32'd20240611));
    rst_n = 0; div_wr_lo = 0; div_wr_hi = 0; div_wdata = 0; xck_in = 0;
    set_mode(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, divisor zero, tick every cycle, tx each 16th
    phase_tag = "R1";
    @(negedge clk);
    chk("R1", "rx_tick first cycle", rx_tick, 1);
    chk("R1", "xck_oe reset", xck_oe, 0);
    for (int i = 0; i < 40; i++) step();

    // R3: low-byte write restarts counter; first tick D cycles later
    phase_tag = "R3";
    div_wdata = 8'd5; div_wr_lo = 1;
    step();
    first_gap = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (first_gap == 0 && rx_tick) first_gap = i + 1;
      check_all();
    end
    chk("R3", "cycles to first tick", first_gap, 5);
    for (int i = 0; i < 30; i++) step();

    // R4: high write does not restart counter
    phase_tag = "R4";
    div_wdata = 8'h01; div_wr_hi = 1;
    for (int i = 0; i < 600; i++) step();
    div_wdata = 8'h00; div_wr_hi = 1;
    step();
    div_wdata = 8'd3; div_wr_lo = 1;
    for (int i = 0; i < 40; i++) step();

    // R6: double speed
    phase_tag = "R6";
    set_mode(0, 1, 0, 0);
    for (int i = 0; i < 100; i++) step();

    // R8: pin ignored in asynchronous mode
    phase_tag = "R8";
    for (int i = 0; i < 60; i++) begin xck_in = i[1]; step(); end

    // R7: master, both polarities
    phase_tag = "R7";
    set_mode(1, 0, 1, 0);
    for (int i = 0; i < 60; i++) step();
    clk_pol = 1;
    for (int i = 0; i < 60; i++) step();

    // R11: double-speed bit toggling in synchronous mode
    phase_tag = "R11";
    for (int i = 0; i < 60; i++) begin dbl_speed = i[0]; step(); end

    // R9: slave, both polarities
    phase_tag = "R9";
    set_mode(1, 0, 0, 0);
    for (int i = 0; i < 80; i++) begin xck_in = i[2]; step(); end
    clk_pol = 1;
    for (int i = 0; i < 80; i++) begin xck_in = i[2]; step(); end

    // Random mix
    phase_tag = "";
    hold = 4;
    for (int i = 0; i < 5000; i++) begin
      step();
      if ($urandom_range(0, 199) == 0)
        {sync_sel, dbl_speed, xck_dir_out, clk_pol} = 4'($urandom);
      if ($urandom_range(0, 79) == 0) begin
        div_wdata = 8'($urandom_range(0, 12)); div_wr_lo = 1;
      end else if ($urandom_range(0, 399) == 0) begin
        div_wdata = 8'($urandom_range(0, 1)); div_wr_hi = 1;
      end
      hold--;
      if (hold == 0) begin
        xck_in = ~xck_in;
        hold = $urandom_range(3, 9);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule